// File: doc/BRIEF.md
# Multiplexed-Bus Target Interface Controller

This block is the target side of a 32-bit synchronous bus on which address and data share one set of lines. When an initiator starts a transaction, the controller samples the command and the address in the first clock. It claims the cycle if the address falls into one of its windows, runs the data phases with the initiator, and stores write bytes or returns read words from a small local storage. Every control line on the bus is active low. Because the AD lines are shared, they appear as an input, an output and an output enable, so that the pad ring can build the tri-state driver.

Three address spaces are decoded. A memory window and an optional I/O window both map onto one word array. An optional configuration space has its own word array and is reached only when the chip-select line for configuration is high during the address phase. A burst moves through consecutive words. If a burst would run past the end of its window, the controller asks the initiator to end it, so that no word outside the window is ever touched.

Top module: `tgt_bus_target`

## Requirements
- R1: While reset is low and right after it, devsel_n_o, trdy_n_o and stop_n_o are high and ad_oe is low.
- R2: Memory command codes 0110, 0111, 1100, 1110 and 1111 are claimed when AD[31:6] equal MEM_BASE[31:6] in the address phase. The address phase is the first clock with frame_n_i low after a clock with it high. In the clock after the address phase devsel_n_o is still high. From the clock after that, devsel_n_o and trdy_n_o are both low.
- R3: An address outside every window is never claimed. devsel_n_o stays high, and the storage keeps its contents.
- R4: Command codes 0000, 0001, 0100, 0101, 1000, 1001 and 1101 are never claimed, whatever the address.
- R5: Configuration codes 1010 (read) and 1011 (write) are claimed only when idsel_i is high and AD[1:0] are 00 in the address phase. The word index is AD[5:2].
- R6: On a write transfer, byte lane k (AD[8k+7:8k]) is stored only when cbe_n_i[k] is low. The other lanes keep their old value.
- R7: On a read, in every clock with trdy_n_o low, ad_oe is high and ad_o carries the word at the current burst address.
- R8: A word moves only on a clock edge where irdy_n_i and trdy_n_o are both low. The word index then advances by one, which is 4 bytes. A clock with irdy_n_i high leaves trdy_n_o low and ad_o unchanged.
- R9: A transfer with frame_n_i high is the last one. In the next clock devsel_n_o, trdy_n_o and stop_n_o are all high. This also holds when that last transfer uses the final word of a window.
- R10: After a transfer of a window's final word with frame_n_i still low, stop_n_o goes low, devsel_n_o stays low and trdy_n_o goes high. They stay that way until a clock with frame_n_i high and irdy_n_i low. In the clock after that, all three are high.
- R11: I/O codes 0010 (read) and 0011 (write) are claimed when AD[31:6] equal IO_BASE[31:6]. They reach the same word array as the memory window, at the same index AD[5:2].
- R12: The configuration space is separate storage. A configuration write does not change the memory window, and a window write does not change the configuration space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Shared address/data lines as seen from the bus |
| ad_o | output | 32 | Read data to drive onto the shared lines |
| ad_oe | output | 1 | Output enable for ad_o |
| cbe_n_i | input | 4 | Command in the address phase, active-low byte enables in data phases |
| frame_n_i | input | 1 | Transaction framing from the initiator |
| irdy_n_i | input | 1 | Initiator ready |
| idsel_i | input | 1 | Chip select for configuration cycles |
| devsel_n_o | output | 1 | Target has claimed the cycle |
| trdy_n_o | output | 1 | Target ready |
| stop_n_o | output | 1 | Target asks the initiator to end the burst |

## Verification
The last data phase of a burst and the end of a window can occur in the same clock. This happens when the initiator raises frame_n_i on the transfer that uses the final word. The final-phase rule must then win: the bench expects a clean turnaround with stop_n_o high, not a disconnect. The bench provokes this with directed bursts that start a known number of words before the window end, in each space. It also provokes it with random bursts whose start index and length place the final phase on the last word. It judges the result clock by clock against the handshake it expects for each burst.

// File: rtl/tgt_pkg.sv
package tgt_pkg;

   localparam int BUS_W = 32;
   localparam int LANES = BUS_W / 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DEC,
      ST_XFER,
      ST_HALT,
      ST_TURN
   } tgt_st_e;

   typedef struct packed {
      logic mem;
      logic io;
      logic cfg;
      logic wr;
   } cmd_cls_t;

   function automatic cmd_cls_t classify(input logic [3:0] code);
      cmd_cls_t r;
      r = '0;
      case (code)
         4'b0010: r.io = 1'b1;
         4'b0011: begin r.io = 1'b1; r.wr = 1'b1; end
         4'b0110, 4'b1100, 4'b1110: r.mem = 1'b1;
         4'b0111, 4'b1111: begin r.mem = 1'b1; r.wr = 1'b1; end
         4'b1010: r.cfg = 1'b1;
         4'b1011: begin r.cfg = 1'b1; r.wr = 1'b1; end
         default: r = '0;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/tgt_decode.sv
module tgt_decode
   import tgt_pkg::*;
#(
   parameter int          WIN_AW   = 4,
   parameter int          CFG_AW   = 4,
   parameter int          IDXW     = 4,
   parameter logic [31:0] MEM_BASE = 32'h8000_0000,
   parameter logic [31:0] IO_BASE  = 32'h0000_2000,
   parameter bit          IO_EN    = 1'b1,
   parameter bit          CFG_EN   = 1'b1
) (
   input  logic [BUS_W-1:0] ad,
   input  logic [3:0]       cmd,
   input  logic             idsel,
   output logic             hit,
   output logic             wr,
   output logic             cfg,
   output logic [IDXW-1:0]  idx
);

   localparam int WIN_LSB = WIN_AW + 2;

   cmd_cls_t cls;
   logic     mem_match;
   logic     io_match;
   logic     cfg_match;

   assign cls       = classify(cmd);
   assign mem_match = cls.mem && (ad[BUS_W-1:WIN_LSB] == MEM_BASE[BUS_W-1:WIN_LSB]);

   if (MEM_BASE[WIN_LSB-1:0] != '0) begin : g_bad_mem
      $error("tgt_decode: MEM_BASE not aligned to window size");
   end

   if (IO_EN) begin : g_io
      if (IO_BASE[WIN_LSB-1:0] != '0) begin : g_bad_io
         $error("tgt_decode: IO_BASE not aligned to window size");
      end
      assign io_match = cls.io && (ad[BUS_W-1:WIN_LSB] == IO_BASE[BUS_W-1:WIN_LSB]);
   end else begin : g_no_io
      assign io_match = 1'b0;
   end

   if (CFG_EN) begin : g_cfg
      assign cfg_match = cls.cfg && idsel && (ad[1:0] == 2'b00);
   end else begin : g_no_cfg
      assign cfg_match = 1'b0;
   end

   assign hit = mem_match || io_match || cfg_match;
   assign wr  = cls.wr;
   assign cfg = cfg_match;
   assign idx = cfg_match ? IDXW'(ad[2 +: CFG_AW]) : IDXW'(ad[2 +: WIN_AW]);

endmodule

// File: rtl/tgt_regs.sv
module tgt_regs
   import tgt_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int AW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [AW-1:0]    widx,
   input  logic [LANES-1:0] be,
   input  logic [BUS_W-1:0] wdata,
   input  logic [AW-1:0]    ridx,
   output logic [BUS_W-1:0] rdata
);

   if (DEPTH != (1 << AW)) begin : g_bad_depth
      $error("tgt_regs: DEPTH must equal 2**AW");
   end

   for (genvar b = 0; b < LANES; b++) begin : g_lane
      logic [7:0] lane_q [DEPTH];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int w = 0; w < DEPTH; w++) lane_q[w] <= '0;
         end else if (we && be[b]) begin
            lane_q[widx] <= wdata[8*b +: 8];
         end
      end

      assign rdata[8*b +: 8] = lane_q[ridx];
   end

endmodule

// File: rtl/tgt_seq.sv
module tgt_seq
   import tgt_pkg::*;
#(
   parameter int IDXW = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            frame_n,
   input  logic            irdy_n,
   input  logic            hit,
   input  logic            wr_in,
   input  logic            cfg_in,
   input  logic [IDXW-1:0] idx_in,
   input  logic            at_end,
   output logic            devsel_n,
   output logic            trdy_n,
   output logic            stop_n,
   output logic            ad_oe,
   output logic            we,
   output logic            cfg_q,
   output logic [IDXW-1:0] cur_idx,
   output logic [IDXW-1:0] rd_idx,
   output logic            load_rd
);

   tgt_st_e st_q, st_d;
   logic    frame_q;
   logic    wr_q;
   logic    addr_ph;
   logic    open;
   logic    xfer;
   logic    last;

   assign addr_ph = !frame_n && frame_q;
   assign open    = (st_q == ST_IDLE) || (st_q == ST_TURN);
   assign xfer    = (st_q == ST_XFER) && !irdy_n;
   assign last    = xfer && frame_n;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE, ST_TURN: st_d = (addr_ph && hit) ? ST_DEC : ST_IDLE;
         ST_DEC:           st_d = ST_XFER;
         ST_XFER: begin
            if (last)              st_d = ST_TURN;
            else if (xfer && at_end) st_d = ST_HALT;
            else                   st_d = ST_XFER;
         end
         ST_HALT:          st_d = (frame_n && !irdy_n) ? ST_TURN : ST_HALT;
         default:          st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         frame_q <= 1'b1;
         wr_q    <= 1'b0;
         cfg_q   <= 1'b0;
         cur_idx <= '0;
      end else begin
         st_q    <= st_d;
         frame_q <= frame_n;
         if (open && addr_ph && hit) begin
            wr_q    <= wr_in;
            cfg_q   <= cfg_in;
            cur_idx <= idx_in;
         end else if (xfer) begin
            cur_idx <= cur_idx + IDXW'(1);
         end
      end
   end

   assign rd_idx   = xfer ? (cur_idx + IDXW'(1)) : cur_idx;
   assign load_rd  = (st_q == ST_DEC) || xfer;
   assign we       = xfer && wr_q;
   assign devsel_n = !((st_q == ST_XFER) || (st_q == ST_HALT));
   assign trdy_n   = (st_q != ST_XFER);
   assign stop_n   = (st_q != ST_HALT);
   assign ad_oe    = !wr_q && (st_q == ST_XFER);

endmodule

// File: rtl/tgt_bus_target.sv
module tgt_bus_target
   import tgt_pkg::*;
#(
   parameter int          WIN_WORDS = 16,
   parameter int          CFG_WORDS = 16,
   parameter logic [31:0] MEM_BASE  = 32'h8000_0000,
   parameter logic [31:0] IO_BASE   = 32'h0000_2000,
   parameter bit          IO_EN     = 1'b1,
   parameter bit          CFG_EN    = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [31:0] ad_i,
   output logic [31:0] ad_o,
   output logic        ad_oe,
   input  logic [3:0]  cbe_n_i,
   input  logic        frame_n_i,
   input  logic        irdy_n_i,
   input  logic        idsel_i,
   output logic        devsel_n_o,
   output logic        trdy_n_o,
   output logic        stop_n_o
);

   localparam int WIN_AW = $clog2(WIN_WORDS);
   localparam int CFG_AW = $clog2(CFG_WORDS);
   localparam int IDXW   = (WIN_AW > CFG_AW) ? WIN_AW : CFG_AW;

   if (WIN_WORDS < 2 || (WIN_WORDS & (WIN_WORDS - 1)) != 0) begin : g_bad_win
      $error("tgt_bus_target: WIN_WORDS must be a power of two >= 2");
   end
   if (CFG_WORDS < 2 || (CFG_WORDS & (CFG_WORDS - 1)) != 0) begin : g_bad_cfg
      $error("tgt_bus_target: CFG_WORDS must be a power of two >= 2");
   end

   logic             dec_hit, dec_wr, dec_cfg;
   logic [IDXW-1:0]  dec_idx;
   logic             we, cfg_q, load_rd, at_end;
   logic [IDXW-1:0]  cur_idx, rd_idx;
   logic [BUS_W-1:0] win_rdata, cfg_rdata, ad_q;
   logic [LANES-1:0] be;

   assign be = ~cbe_n_i;

   tgt_decode #(
      .WIN_AW(WIN_AW), .CFG_AW(CFG_AW), .IDXW(IDXW),
      .MEM_BASE(MEM_BASE), .IO_BASE(IO_BASE),
      .IO_EN(IO_EN), .CFG_EN(CFG_EN)
   ) u_dec (
      .ad(ad_i), .cmd(cbe_n_i), .idsel(idsel_i),
      .hit(dec_hit), .wr(dec_wr), .cfg(dec_cfg), .idx(dec_idx)
   );

   tgt_seq #(.IDXW(IDXW)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .frame_n(frame_n_i), .irdy_n(irdy_n_i),
      .hit(dec_hit), .wr_in(dec_wr), .cfg_in(dec_cfg), .idx_in(dec_idx),
      .at_end(at_end),
      .devsel_n(devsel_n_o), .trdy_n(trdy_n_o), .stop_n(stop_n_o),
      .ad_oe(ad_oe), .we(we), .cfg_q(cfg_q),
      .cur_idx(cur_idx), .rd_idx(rd_idx), .load_rd(load_rd)
   );

   assign at_end = cfg_q ? (&cur_idx[CFG_AW-1:0]) : (&cur_idx[WIN_AW-1:0]);

   tgt_regs #(.DEPTH(WIN_WORDS), .AW(WIN_AW)) u_win (
      .clk(clk), .rst_n(rst_n),
      .we(we && !cfg_q), .widx(cur_idx[WIN_AW-1:0]), .be(be), .wdata(ad_i),
      .ridx(rd_idx[WIN_AW-1:0]), .rdata(win_rdata)
   );

   if (CFG_EN) begin : g_cfg_store
      tgt_regs #(.DEPTH(CFG_WORDS), .AW(CFG_AW)) u_cfg (
         .clk(clk), .rst_n(rst_n),
         .we(we && cfg_q), .widx(cur_idx[CFG_AW-1:0]), .be(be), .wdata(ad_i),
         .ridx(rd_idx[CFG_AW-1:0]), .rdata(cfg_rdata)
      );
   end else begin : g_no_cfg_store
      assign cfg_rdata = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ad_q <= '0;
      else if (load_rd) ad_q <= cfg_q ? cfg_rdata : win_rdata;
   end

   assign ad_o = ad_q;

endmodule

// File: rtl/tgt_bus_target_chk.sv
module tgt_bus_target_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] ad_o,
   input logic        ad_oe,
   input logic [3:0]  cbe_n_i,
   input logic        frame_n_i,
   input logic        irdy_n_i,
   input logic        idsel_i,
   input logic        devsel_n_o,
   input logic        trdy_n_o,
   input logic        stop_n_o
);

   logic frm_q;
   logic addr_ph;
   logic rsvd;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) frm_q <= 1'b1;
      else        frm_q <= frame_n_i;
   end

   assign addr_ph = !frame_n_i && frm_q;
   assign rsvd    = (cbe_n_i == 4'b0100) || (cbe_n_i == 4'b0101) ||
                    (cbe_n_i == 4'b1000) || (cbe_n_i == 4'b1001);

   assert_trdy_claimed_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !trdy_n_o |-> !devsel_n_o);

   assert_rsvd_unclaimed_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_ph && rsvd) |-> ##2 devsel_n_o);

   assert_cfg_needs_sel_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_ph && cbe_n_i[3:1] == 3'b101 && !idsel_i) |-> ##2 devsel_n_o);

   assert_oe_with_trdy_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> !trdy_n_o);

   assert_wait_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!trdy_n_o && irdy_n_i) |=> (!trdy_n_o && $stable(ad_o)));

   assert_final_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!trdy_n_o && !irdy_n_i && frame_n_i) |=> (devsel_n_o && trdy_n_o && stop_n_o));

   assert_halt_shape_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !stop_n_o |-> (trdy_n_o && !devsel_n_o));

endmodule

bind tgt_bus_target tgt_bus_target_chk u_chk (.*);

// File: tb/sim_tgt_bus_target.sv
module sim_tgt_bus_target;

   localparam logic [31:0] MEMB  = 32'h8000_0000;
   localparam logic [31:0] IOB   = 32'h0000_2000;
   localparam int          NW    = 16;
   localparam int          S_DEC = 0, S_DATA = 1, S_STOP = 2, S_TURN = 3;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [31:0] ad_i;
   logic [31:0] ad_o;
   logic        ad_oe;
   logic [3:0]  cbe_n;
   logic        frame_n, irdy_n, idsel;
   logic        devsel_n, trdy_n, stop_n;

   int n_chk  = 0;
   int n_fail = 0;
   logic [31:0] win_m [NW];
   logic [31:0] cfg_m [NW];

   always #5 clk = ~clk;

   tgt_bus_target #(
      .WIN_WORDS(NW), .CFG_WORDS(NW), .MEM_BASE(MEMB), .IO_BASE(IOB),
      .IO_EN(1'b1), .CFG_EN(1'b1)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .ad_o(ad_o), .ad_oe(ad_oe),
      .cbe_n_i(cbe_n), .frame_n_i(frame_n), .irdy_n_i(irdy_n), .idsel_i(idsel),
      .devsel_n_o(devsel_n), .trdy_n_o(trdy_n), .stop_n_o(stop_n)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic bit exp_decode(input logic [3:0] c, input logic [31:0] a, input logic s,
                                     output bit cf, output int ix, output bit w);
      bit m, io, cg;
      w  = c[0];
      m  = (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) || (c == 4'b1110) || (c == 4'b1111);
      io = (c == 4'b0010) || (c == 4'b0011);
      cg = (c == 4'b1010) || (c == 4'b1011);
      cf = cg;
      ix = int'(a[5:2]);
      if (cg) return s && (a[1:0] == 2'b00);
      if (m)  return a[31:6] == MEMB[31:6];
      if (io) return a[31:6] == IOB[31:6];
      return 1'b0;
   endfunction

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw, input logic [3:0] be);
      logic [31:0] r;
      r = old;
      for (int k = 0; k < 4; k++) if (be[k]) r[8*k +: 8] = nw[8*k +: 8];
      return r;
   endfunction

   // One whole transaction as initiator; checks every clock of the target handshake.
   task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input logic sel,
                      input int count, input int wait_pct, input logic [3:0] be_fix,
                      input bit rand_be, input string tag);
      bit claim, is_cfg, wr, wt;
      int idx, avail, i, st;
      logic [2:0]  exp_o;
      logic [31:0] wd, mdl;
      logic [3:0]  be;
      string       t;
      claim = exp_decode(cmd, addr, sel, is_cfg, idx, wr);
      avail = NW - idx;
      i = 0;
      st = S_DEC;
      @(negedge clk);
      frame_n = 1'b0; irdy_n = 1'b1; ad_i = addr; cbe_n = cmd; idsel = sel;
      for (int g = 0; g < 300; g++) begin
         @(negedge clk);
         if (!claim)             begin exp_o = 3'b111; t = tag; end
         else if (st == S_DEC)   begin exp_o = 3'b111; t = "R2"; end
         else if (st == S_DATA)  begin exp_o = 3'b001; t = "R8"; end
         else if (st == S_STOP)  begin exp_o = 3'b010; t = "R10"; end
         else                    begin exp_o = 3'b111; t = "R9"; end
         chk({devsel_n, trdy_n, stop_n} == exp_o, t, {29'd0, devsel_n, trdy_n, stop_n}, {29'd0, exp_o});
         idsel = 1'b0;
         if (!claim) begin
            if (i >= count) break;
            irdy_n = 1'b0; frame_n = (i == count - 1); ad_i = $urandom; cbe_n = 4'h0;
            i++;
            continue;
         end
         if (st == S_TURN) break;
         if (st == S_STOP) begin
            frame_n = 1'b1; irdy_n = 1'b0; ad_i = 32'h0;
            st = S_TURN;
            continue;
         end
         if (st == S_DEC) begin
            irdy_n = 1'b1; frame_n = 1'b0; ad_i = 32'h0; cbe_n = 4'h0;
            st = S_DATA;
            continue;
         end
         wt = (int'($urandom % 100) < wait_pct);
         wd = $urandom;
         be = rand_be ? 4'($urandom) : be_fix;
         irdy_n  = wt;
         frame_n = !wt && (i == count - 1);
         ad_i    = wr ? wd : 32'h0;
         cbe_n   = wr ? ~be : 4'h0;
         if (!wt) begin
            if (wr) begin
               if (is_cfg) cfg_m[idx + i] = merge(cfg_m[idx + i], wd, be);
               else        win_m[idx + i] = merge(win_m[idx + i], wd, be);
            end else begin
               mdl = is_cfg ? cfg_m[idx + i] : win_m[idx + i];
               chk(ad_oe === 1'b1, "R7 oe", {31'd0, ad_oe}, 32'd1);
               chk(ad_o === mdl, is_cfg ? "R7 R12 cfg data" : "R7 R11 data", ad_o, mdl);
            end
            i++;
            if (i == count)      st = S_TURN;
            else if (i == avail) st = S_STOP;
         end
      end
      @(negedge clk);
      frame_n = 1'b1; irdy_n = 1'b1; ad_i = 32'h0; cbe_n = 4'h0; idsel = 1'b0;
      chk({devsel_n, trdy_n, stop_n, ad_oe} == 4'b1110, "R9 idle", {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'he);
   endtask

   task automatic dump_check(input bit cfgsp, input string tag);
      txn(cfgsp ? 4'b1010 : 4'b0110, cfgsp ? 32'h0 : MEMB, cfgsp, NW, 0, 4'h0, 1'b0, tag);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      logic [3:0] codes [7];
      void'($urandom(32'd20240611));
      for (int k = 0; k < NW; k++) begin win_m[k] = '0; cfg_m[k] = '0; end
      rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; idsel = 1'b0; ad_i = '0; cbe_n = '0;
      repeat (2) @(negedge clk);
      chk({devsel_n, trdy_n, stop_n, ad_oe} == 4'b1110, "R1 in reset", {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'he);
      rst_n = 1'b1;
      @(negedge clk);
      chk({devsel_n, trdy_n, stop_n, ad_oe} == 4'b1110, "R1 after reset", {28'd0, devsel_n, trdy_n, stop_n, ad_oe}, 32'he);

      // R2 R6: full-lane memory write burst, then read back with wait states (R7 R8)
      txn(4'b0111, MEMB + 32'd8, 1'b0, 4, 0, 4'hF, 1'b0, "R2");
      txn(4'b0110, MEMB + 32'd8, 1'b0, 4, 40, 4'h0, 1'b0, "R8");
      // R6: partial byte enables
      txn(4'b0111, MEMB + 32'd8, 1'b0, 3, 0, 4'b0101, 1'b0, "R6");
      txn(4'b0111, MEMB + 32'd12, 1'b0, 1, 0, 4'b0000, 1'b0, "R6");
      txn(4'b0110, MEMB + 32'd8, 1'b0, 3, 0, 4'h0, 1'b0, "R6");
      // R11: I/O window shares storage; alias memory codes
      txn(4'b0011, IOB + 32'd20, 1'b0, 2, 20, 4'hF, 1'b0, "R11");
      txn(4'b1100, MEMB + 32'd16, 1'b0, 4, 0, 4'h0, 1'b0, "R11");
      txn(4'b1111, MEMB + 32'd40, 1'b0, 2, 0, 4'hF, 1'b0, "R11");
      txn(4'b1110, MEMB + 32'd36, 1'b0, 4, 30, 4'h0, 1'b0, "R11");
      txn(4'b0010, IOB + 32'd36, 1'b0, 3, 0, 4'h0, 1'b0, "R11");
      // R5 R12: configuration space
      txn(4'b1011, 32'h0000_0010, 1'b1, 3, 0, 4'hF, 1'b0, "R5");
      txn(4'b1011, 32'h0000_0030, 1'b0, 2, 0, 4'hF, 1'b0, "R5 no idsel");
      txn(4'b1011, 32'h0000_0031, 1'b1, 1, 0, 4'hF, 1'b0, "R5 ad10");
      txn(4'b1010, 32'h0000_0000, 1'b0, 2, 0, 4'h0, 1'b0, "R5 no idsel");
      dump_check(1'b1, "R12");
      dump_check(1'b0, "R12");
      // R3: outside windows; R4: reserved and unlisted codes
      txn(4'b0111, MEMB + 32'h40, 1'b0, 2, 0, 4'hF, 1'b0, "R3");
      txn(4'b0011, IOB - 32'h4, 1'b0, 2, 0, 4'hF, 1'b0, "R3");
      codes = '{4'b0100, 4'b0101, 4'b1000, 4'b1001, 4'b0000, 4'b0001, 4'b1101};
      foreach (codes[k]) txn(codes[k], MEMB + 32'd4, 1'b1, 2, 0, 4'hF, 1'b0, "R4");
      dump_check(1'b0, "R3 R4");
      // R10: burst runs past window end; R9: final phase lands on last word
      txn(4'b0111, MEMB + 32'd56, 1'b0, 5, 0, 4'hF, 1'b0, "R10");
      txn(4'b0110, MEMB + 32'd52, 1'b0, 6, 25, 4'h0, 1'b0, "R10");
      txn(4'b0111, MEMB + 32'd56, 1'b0, 2, 0, 4'hF, 1'b0, "R9");
      txn(4'b0110, MEMB + 32'd60, 1'b0, 1, 0, 4'h0, 1'b0, "R9");
      txn(4'b1011, 32'h0000_0038, 1'b1, 2, 0, 4'hF, 1'b0, "R9");
      txn(4'b1010, 32'h0000_0034, 1'b1, 4, 0, 4'h0, 1'b0, "R10");
      // constrained random mix
      for (int n = 0; n < 150; n++) begin
         logic [3:0]  c;
         logic [31:0] a;
         int          sp;
         c  = 4'($urandom);
         sp = int'($urandom % 8);
         a  = (sp < 4) ? (MEMB + {26'd0, 4'($urandom), 2'b00}) :
              (sp < 6) ? (IOB  + {26'd0, 4'($urandom), 2'b00}) :
              (sp < 7) ? {26'd0, 4'($urandom), 2'b00} : 32'($urandom);
         txn(c, a, 1'($urandom), 1 + int'($urandom % 6), 25, 4'h0, 1'b1, "R3 R4 R5 rand");
      end
      dump_check(1'b0, "R6 final");
      dump_check(1'b1, "R12 final");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule